// File: doc/BRIEF.md
# Serial Speech Data ROM

This block is a serial-access byte memory meant to feed a speech synthesizer over a very narrow link. The synthesizer drives a 4-bit nibble bus and two mode lines, all sampled on a ROM clock enable. Five nibble-load operations build a 20-bit word. The low 14 bits are a byte address, the next 4 bits are a chip-select code, and the top 2 bits are don't-care. The chip only answers when the code equals its `CS_MASK` parameter. Once an address is latched, each read operation shifts out one data bit. The byte address advances on its own every 8 bits, so the contents look like one long bit stream.

An address load is always followed by two dummy read pulses. These return nothing. Their purpose is to put the nibble position back to the start. Any read-type operation resets that position, so a partly loaded word is dropped when a read arrives. A read-and-branch operation fetches two bytes at the current address and jumps to the 14-bit pointer they hold. The first byte gives the low 8 bits and the low 6 bits of the second byte give the high bits. The memory is an internal array whose contents are computed from parameters. Its read port is synchronous, so it maps to block RAM. For this reason, ROM clock enable pulses must be at least 4 `clk` cycles apart.

Top module: `serial_voice_rom`

## Requirements
- R1: Mode {m1,m0}=2'b10 on an enabled edge loads `nib_in` into the next nibble slot. Nibble k fills word bits [4k+3:4k]. On the fifth nibble, word bits [13:0] become the byte address.
- R2: After the fifth nibble, the chip is selected only if word bits [17:14] equal `CS_MASK` (default 4'hA). While it is deselected, `sdo_en` stays 0 on every read.
- R3: Word bits [19:18] have no effect on the address or on selection.
- R4: Mode 2'b01 on an enabled edge (a real read while selected) sets `sdo` to the next bit of the current byte, least significant bit first. It also sets `sdo_en` to 1. Both values hold until the next enabled edge.
- R5: After bit 7 of a byte, the byte address increments. Reading continues at bit 0 of the following byte, and the memory index wraps modulo the memory depth.
- R6: Any enabled edge with m0=1 returns the nibble slot to the first nibble, so a partial load is discarded.
- R7: The first two read pulses after a completed load are dummy reads. They give `sdo_en`=0 and do not move the bit position.
- R8: Mode 2'b11 while selected reads byte b0 at the current address and b1 at the next address. The new address is {b1[5:0], b0}. Reading restarts at bit 0 with no dummy reads, and `sdo_en` is 0 after the branch pulse.
- R9: Mode 2'b00 changes no state and gives `sdo_en`=0. A read that was interrupted by idle pulses continues at the same bit.
- R10: After reset, `sdo` and `sdo_en` are 0 and the chip is deselected. `sdo` changes only on enabled edges.
- R11: The byte at memory index i is (i*INIT_MUL + INIT_ADD) mod 256. The defaults are INIT_MUL=37 and INIT_ADD=11, and the memory index is the low 8 address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | ROM clock enable, one pulse per operation |
| mode_m0 | input | 1 | Mode line 0 (read) |
| mode_m1 | input | 1 | Mode line 1 (load) |
| nib_in | input | 4 | Address nibble bus |
| sdo | output | 1 | Serial data bit |
| sdo_en | output | 1 | High while `sdo` carries a valid bit |

## Verification
Every operation is applied as a one-cycle enable pulse followed by three quiet cycles. `sdo` and `sdo_en` are registered on the enabled edge itself, so the bench samples them three cycles after the pulse. By that point the bit from the previous read pulse is stable. A branch finishes its two-byte fetch within three cycles of its pulse, so the next read already uses the new address. The bench runs through all 256 memory indices, as well as wrap-around, a chip-select mismatch, the don't-care bits, partial loads, idle gaps and branches. Every expected bit is derived from the content formula.

// File: rtl/svr_pkg.sv
package svr_pkg;
  // Mode encoding {m1, m0}
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_READ   = 2'b01,
    MODE_LOAD   = 2'b10,
    MODE_BRANCH = 2'b11
  } svr_mode_t;

  typedef enum logic [1:0] {
    BR_IDLE = 2'd0,
    BR_WAIT = 2'd1,
    BR_LOAD = 2'd2
  } svr_br_t;
endpackage

// File: rtl/svr_nib_loader.sv
module svr_nib_loader #(
  parameter int NIB_N = 5,
  parameter int NIB_W = 4,
  localparam int WORD_W = NIB_N * NIB_W,
  localparam int PTR_W  = $clog2(NIB_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              clear,
  input  logic [NIB_W-1:0]  nib,
  output logic              word_done,
  output logic [WORD_W-1:0] word
);
  logic [PTR_W-1:0]  ptr_q;
  logic [NIB_W-1:0]  slot_q [NIB_N-1];

  assign word_done = load_en && (ptr_q == PTR_W'(NIB_N - 1));

  // Assembled word: stored slots plus the nibble arriving now as the last one
  for (genvar g = 0; g < NIB_N; g++) begin : g_word
    if (g == NIB_N - 1) begin : g_last
      assign word[g*NIB_W +: NIB_W] = nib;
    end else begin : g_slot
      assign word[g*NIB_W +: NIB_W] = slot_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ptr_q <= '0;
    end else if (load_en) begin
      ptr_q <= word_done ? '0 : ptr_q + PTR_W'(1);
    end
  end

  for (genvar g = 0; g < NIB_N - 1; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[g] <= '0;
      end else if (load_en && !clear && ptr_q == PTR_W'(g)) begin
        slot_q[g] <= nib;
      end
    end
  end
endmodule

// File: rtl/svr_byte_rom.sv
module svr_byte_rom #(
  parameter int MEM_AW   = 8,
  parameter int INIT_MUL = 37,
  parameter int INIT_ADD = 11,
  localparam int DEPTH   = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic [MEM_AW-1:0] idx,
  output logic [7:0]        rd_q
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'((i * INIT_MUL + INIT_ADD) % 256);
    end
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[idx];
  end
endmodule

// File: rtl/serial_voice_rom.sv
module serial_voice_rom #(
  parameter int         ADDR_W   = 14,
  parameter int         CS_W     = 4,
  parameter int         DC_W     = 2,
  parameter int         NIB_W    = 4,
  parameter int         MEM_AW   = 8,
  parameter logic [3:0] CS_MASK  = 4'hA,
  parameter int         INIT_MUL = 37,
  parameter int         INIT_ADD = 11,
  localparam int WORD_W = ADDR_W + CS_W + DC_W,
  localparam int NIB_N  = WORD_W / NIB_W,
  localparam int HI_W   = ADDR_W - 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             mode_m0,
  input  logic             mode_m1,
  input  logic [NIB_W-1:0] nib_in,
  output logic             sdo,
  output logic             sdo_en
);
  import svr_pkg::*;

  svr_mode_t          mode;
  logic               word_done;
  logic [WORD_W-1:0]  word;
  logic [7:0]         rd_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [2:0]         bit_q;
  logic               sel_q;
  logic [1:0]         dummy_q;
  svr_br_t            br_q;
  logic [7:0]         br_lo_q;
  logic               unused_dc;

  assign mode      = svr_mode_t'({mode_m1, mode_m0});
  assign unused_dc = ^word[WORD_W-1 -: DC_W];

  svr_nib_loader #(.NIB_N(NIB_N), .NIB_W(NIB_W)) u_loader (
    .clk      (clk),
    .rst      (rst),
    .load_en  (clk_en && mode == MODE_LOAD),
    .clear    (clk_en && mode_m0),
    .nib      (nib_in),
    .word_done(word_done),
    .word     (word)
  );

  svr_byte_rom #(.MEM_AW(MEM_AW), .INIT_MUL(INIT_MUL), .INIT_ADD(INIT_ADD)) u_rom (
    .clk (clk),
    .idx (addr_q[MEM_AW-1:0]),
    .rd_q(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      bit_q   <= '0;
      sel_q   <= 1'b0;
      dummy_q <= '0;
      br_q    <= BR_IDLE;
      br_lo_q <= '0;
      sdo     <= 1'b0;
      sdo_en  <= 1'b0;
    end else begin
      // Branch fetch: wait for second byte, then jump
      case (br_q)
        BR_WAIT: br_q <= BR_LOAD;
        BR_LOAD: begin
          addr_q <= {rd_q[HI_W-1:0], br_lo_q};
          br_q   <= BR_IDLE;
        end
        default: br_q <= BR_IDLE;
      endcase

      if (clk_en) begin
        sdo_en <= 1'b0;
        case (mode)
          MODE_LOAD: begin
            if (word_done) begin
              addr_q  <= word[ADDR_W-1:0];
              sel_q   <= (word[ADDR_W +: CS_W] == CS_MASK);
              bit_q   <= '0;
              dummy_q <= 2'd2;
            end
          end
          MODE_READ: begin
            if (dummy_q != 2'd0) begin
              dummy_q <= dummy_q - 2'd1;
            end else if (sel_q) begin
              sdo    <= rd_q[bit_q];
              sdo_en <= 1'b1;
              bit_q  <= bit_q + 3'd1;
              if (bit_q == 3'd7) addr_q <= addr_q + ADDR_W'(1);
            end
          end
          MODE_BRANCH: begin
            if (sel_q) begin
              br_lo_q <= rd_q;
              addr_q  <= addr_q + ADDR_W'(1);
              br_q    <= BR_WAIT;
              bit_q   <= '0;
              dummy_q <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/svr_checker.sv
module svr_checker (
  input logic clk,
  input logic rst,
  input logic clk_en,
  input logic mode_m0,
  input logic mode_m1,
  input logic sdo,
  input logic sdo_en,
  input logic sel_q
);
  // R2: valid data only appears when the chip was selected
  a_r2_oe_needs_select: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_en) |-> $past(sel_q));

  // R4: sdo_en rises only after an enabled read edge
  a_r4_oe_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_en) |-> $past(clk_en && mode_m0 && !mode_m1));

  // R9: idle pulse drops sdo_en
  a_r9_idle_no_oe: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !mode_m0 && !mode_m1) |=> !sdo_en);

  // R1: load pulse never yields valid data
  a_r1_load_no_oe: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !mode_m0 && mode_m1) |=> !sdo_en);

  // R8: branch pulse never yields valid data
  a_r8_branch_no_oe: assert property (@(posedge clk) disable iff (rst)
    (clk_en && mode_m0 && mode_m1) |=> !sdo_en);

  // R10: outputs move only on enabled edges
  a_r10_sdo_stable: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(sdo) && $stable(sdo_en)));
endmodule

bind serial_voice_rom svr_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .clk_en (clk_en),
  .mode_m0(mode_m0),
  .mode_m1(mode_m1),
  .sdo    (sdo),
  .sdo_en (sdo_en),
  .sel_q  (sel_q)
);

// File: tb/serial_voice_rom_tb.sv
module serial_voice_rom_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b0;
  logic       mode_m0 = 1'b0;
  logic       mode_m1 = 1'b0;
  logic [3:0] nib_in = 4'd0;
  logic       sdo, sdo_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [3:0] MASK = 4'hA;

  always #2 clk = ~clk;

  serial_voice_rom u_dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .mode_m0(mode_m0),
    .mode_m1(mode_m1), .nib_in(nib_in), .sdo(sdo), .sdo_en(sdo_en)
  );

  function automatic logic [7:0] mem_byte(input int i);
    return 8'(((i % 256) * 37 + 11) % 256);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic m1, input logic m0, input logic [3:0] n);
    @(negedge clk);
    mode_m1 = m1; mode_m0 = m0; nib_in = n; clk_en = 1'b1;
    @(negedge clk);
    clk_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic load_word(input logic [13:0] a, input logic [3:0] cs, input logic [1:0] dc);
    logic [19:0] w;
    w = {dc, cs, a};
    for (int k = 0; k < 5; k++) pulse(1'b1, 1'b0, w[4*k +: 4]);
  endtask

  task automatic read_bits(input int n, output logic [7:0] b, output bit oe_all, output bit oe_any);
    b = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int k = 0; k < n; k++) begin
      pulse(1'b0, 1'b1, 4'd0);
      b[k] = sdo;
      oe_all &= sdo_en;
      oe_any |= sdo_en;
    end
  endtask

  task automatic dummies();
    pulse(1'b0, 1'b1, 4'd0);
    pulse(1'b0, 1'b1, 4'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, e;
    bit all, any;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(sdo == 1'b0 && sdo_en == 1'b0, "R10 reset", {sdo, sdo_en}, 0);
    // R2/R10: deselected after reset, reads give nothing
    read_bits(2, b, all, any);
    check(!any, "R10 deselected after reset", any, 0);

    // R7: dummy reads
    load_word(14'h0025, MASK, 2'b00);
    pulse(1'b0, 1'b1, 4'd0);
    check(!sdo_en, "R7 dummy 1", sdo_en, 0);
    pulse(1'b0, 1'b1, 4'd0);
    check(!sdo_en, "R7 dummy 2", sdo_en, 0);
    read_bits(8, b, all, any);
    check(all && b == mem_byte(16'h25), "R7 R4 first byte after dummies", b, mem_byte(16'h25));

    // R1 R4 R5 R11: sweep every memory index, two bytes each
    for (int a = 0; a < 256; a++) begin
      load_word(14'(a + 256 * (a % 7)), MASK, 2'b00);
      dummies();
      read_bits(8, b, all, any);
      check(all && b == mem_byte(a), "R1 R4 R11 byte", b, mem_byte(a));
      read_bits(8, b, all, any);
      check(all && b == mem_byte(a + 1), "R5 next byte", b, mem_byte(a + 1));
    end

    // R5: wrap of memory index
    load_word(14'h00FF, MASK, 2'b00);
    dummies();
    read_bits(8, b, all, any);
    read_bits(8, b, all, any);
    check(b == mem_byte(0), "R5 wrap", b, mem_byte(0));

    // R3: don't-care bits
    load_word(14'h0042, MASK, 2'b11);
    dummies();
    read_bits(8, b, all, any);
    check(all && b == mem_byte(16'h42), "R3 dont care", b, mem_byte(16'h42));

    // R2: mismatched chip select
    load_word(14'h0010, MASK ^ 4'h1, 2'b00);
    dummies();
    read_bits(8, b, all, any);
    check(!any, "R2 mismatch no data", any, 0);
    load_word(14'h0010, 4'h0, 2'b00);
    dummies();
    read_bits(8, b, all, any);
    check(!any, "R2 mismatch cs 0", any, 0);

    // R6: partial load discarded by a read
    load_word(14'h0030, MASK, 2'b00);
    dummies();
    pulse(1'b1, 1'b0, 4'hF);
    pulse(1'b1, 1'b0, 4'hF);
    pulse(1'b0, 1'b1, 4'd0);
    load_word(14'h0077, MASK, 2'b00);
    dummies();
    read_bits(8, b, all, any);
    check(all && b == mem_byte(16'h77), "R6 pointer reset", b, mem_byte(16'h77));

    // R9: idle pulses keep bit position
    load_word(14'h0051, MASK, 2'b00);
    dummies();
    e = mem_byte(16'h51);
    read_bits(3, b, all, any);
    check(b[2:0] == e[2:0], "R9 first bits", b[2:0], e[2:0]);
    pulse(1'b0, 1'b0, 4'h5);
    check(!sdo_en, "R9 idle no oe", sdo_en, 0);
    pulse(1'b0, 1'b0, 4'h3);
    read_bits(5, b, all, any);
    check(all && b[4:0] == e[7:3], "R9 resume", b[4:0], e[7:3]);
    read_bits(8, b, all, any);
    check(b == mem_byte(16'h52), "R9 R5 next byte", b, mem_byte(16'h52));

    // R8: read-and-branch
    for (int a = 3; a < 256; a += 29) begin
      int t;
      load_word(14'(a), MASK, 2'b00);
      pulse(1'b1, 1'b1, 4'd0);
      check(!sdo_en, "R8 branch no oe", sdo_en, 0);
      t = mem_byte(a);
      read_bits(8, b, all, any);
      check(all && b == mem_byte(t), "R8 branch target", b, mem_byte(t));
      read_bits(8, b, all, any);
      check(b == mem_byte(t + 1), "R8 branch continue", b, mem_byte(t + 1));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule